// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the four level-sensitive interrupt pins of every device slot on a small PCI bus and turns them into the sixteen inputs of a legacy interrupt controller. The mapping has two stages. First, a fixed rotation that depends on the slot number folds each pin onto one of four shared interrupt lines. This spreads the commonly used first pin of different slots across different lines. Second, four byte-wide steering registers, one per shared line, each name the legacy input that their line drives. When several lines name the same input, that input carries the OR of those lines.

Firmware programs the steering registers through a small byte-wide register port. It reads them back the same way. A line whose register holds a value of sixteen or more drives nothing. A parameter chooses the reset contents of the registers: either every line disabled, or a fixed profile that places lines A and B on input 10 and lines C and D on input 11. Pin levels are captured in a register on every clock. Each legacy output is therefore a registered function of the pins and the steering registers.

Top module: `pci_irq_router`

## Requirements
- R1: Pin p (0 = INTA to 3 = INTD) of slot s (1 to NUM_SLOTS) is carried on `slotPins[(s-1)*4 + p]`. It is folded onto shared line (p + s - 1) mod 4. The shared lines are numbered 0 to 3 (A to D).
- R2: The steering register of shared line k sits at register address 0x60 + k. Line A uses address 0x60 and line D uses 0x63. `regRdata` returns the stored byte for these addresses in the same cycle. It returns 0x00 for any other address.
- R3: A write (`regWe` high at a rising edge) to 0x60..0x63 stores `regWdata` at that edge. A write to any other address changes no steering register and no output.
- R4: A steering value from 0 to 15 connects the line to the legacy input of that number. A value of 16 or more connects it to no input.
- R5: Each legacy output is the OR of every shared line whose steering register holds that output's number. Several lines may share one input.
- R6: Reset clears all captured line levels to zero. It also loads 0x80 into all four steering registers when RESET_PROFILE = 0, or 0x0A, 0x0A, 0x0B, 0x0B into lines A to D when RESET_PROFILE = 1.
- R7: A change on a slot pin, or a write to a steering register, shows on `legacyIrq` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slotPins | input | NUM_SLOTS*4 | Interrupt pins of all slots, four per slot |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from the address |
| legacyIrq | output | NUM_LEGACY | Levels for the legacy interrupt controller inputs |

## Verification
Every result on `legacyIrq` is due one rising edge after its cause. This holds both for a pin level, which is captured into the line register, and for a steering write, which lands in the register at the edge of the strobe. Read data is due in the same cycle as the address. The bench drives every stimulus just after a falling edge and lets one rising edge pass. It then compares outputs at the following falling edge, so each check looks at the cycle in which the result first becomes valid. Reads are taken a short delay after the address changes, with no clock edge between.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int LINES = 4;
  localparam int ROUTE_W = 8;
  localparam logic [7:0] ROUTE_BASE = 8'h60;
  localparam logic [7:0] ROUTE_OFF = 8'h80;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic [LINES-1:0]   wrLine;
    logic [LINES-1:0]   rdLine;
    logic [ROUTE_W-1:0] wrData;
  } ctrlStrobes_t;

  // reset contents of a steering register, chosen by profile
  function automatic logic [ROUTE_W-1:0] resetRoute(input int profile, input int line);
    if (profile == 0) return ROUTE_OFF;
    return (line < 2) ? 8'd10 : 8'd11;
  endfunction

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic         regWe,
  input  logic [7:0]   regAddr,
  input  logic [7:0]   regWdata,
  output ctrlStrobes_t strobes
);

  logic [LINES-1:0] hitLine;

  for (genvar l = 0; l < LINES; l++) begin : g_dec
    assign hitLine[l] = (regAddr == ROUTE_BASE + 8'(l));
  end

  always_comb begin
    strobes.rdLine = hitLine;
    strobes.wrLine = regWe ? hitLine : '0;
    strobes.wrData = regWdata;
  end

endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int NUM_LEGACY    = 16,
  parameter int RESET_PROFILE = 0,
  localparam int PIN_W        = NUM_SLOTS * LINES
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobes_t             strobes,
  input  logic [PIN_W-1:0]         slotPins,
  output logic [LINES*ROUTE_W-1:0] routeFlat,
  output logic [ROUTE_W-1:0]       rdData,
  output logic [NUM_LEGACY-1:0]    legacyIrq
);

  logic [ROUTE_W-1:0] routeReg [LINES];
  logic [LINES-1:0]   lineNext;
  logic [LINES-1:0]   lineLevel;

  // steering registers
  for (genvar l = 0; l < LINES; l++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 routeReg[l] <= resetRoute(RESET_PROFILE, l);
      else if (strobes.wrLine[l]) routeReg[l] <= strobes.wrData;
    end
    assign routeFlat[l*ROUTE_W +: ROUTE_W] = routeReg[l];
  end

  // slot rotation: slot index s (slot number s+1) pin p lands on (p+s) mod LINES
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [NUM_SLOTS-1:0] rotated;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int PIN = (l - (s % LINES) + LINES) % LINES;
      assign rotated[s] = slotPins[s*LINES + PIN];
    end
    assign lineNext[l] = |rotated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lineLevel <= '0;
    else        lineLevel <= lineNext;
  end

  // read-back mux, one-hot select
  always_comb begin
    rdData = '0;
    for (int l = 0; l < LINES; l++) begin
      if (strobes.rdLine[l]) rdData = rdData | routeReg[l];
    end
  end

  // steering: output n is the OR of lines whose register equals n
  for (genvar n = 0; n < NUM_LEGACY; n++) begin : g_out
    logic [LINES-1:0] match;
    for (genvar l = 0; l < LINES; l++) begin : g_m
      assign match[l] = lineLevel[l] && (routeReg[l] == ROUTE_W'(n));
    end
    assign legacyIrq[n] = |match;
  end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_SLOTS     = 8,
  parameter int NUM_LEGACY    = 16,
  parameter int RESET_PROFILE = 0
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS*LINES-1:0]  slotPins,
  input  logic                        regWe,
  input  logic [7:0]                  regAddr,
  input  logic [7:0]                  regWdata,
  output logic [7:0]                  regRdata,
  output logic [NUM_LEGACY-1:0]       legacyIrq
);

  ctrlStrobes_t               strobes;
  logic [LINES*ROUTE_W-1:0]   routeFlat;

  irq_route_ctrl u_ctrl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobes  (strobes)
  );

  irq_route_datapath #(
    .NUM_SLOTS     (NUM_SLOTS),
    .NUM_LEGACY    (NUM_LEGACY),
    .RESET_PROFILE (RESET_PROFILE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .slotPins  (slotPins),
    .routeFlat (routeFlat),
    .rdData    (regRdata),
    .legacyIrq (legacyIrq)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SLOTS  = 8,
  parameter int NUM_LEGACY = 16
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_SLOTS*4-1:0]  slotPins,
  input logic                    regWe,
  input logic [7:0]              regAddr,
  input logic [7:0]              regWdata,
  input logic [NUM_LEGACY-1:0]   legacyIrq,
  input logic [31:0]             routeFlat
);

  // R3
  write_line_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == 8'h60) |=> (routeFlat[7:0] == $past(regWdata)));

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && (regAddr < 8'h60 || regAddr > 8'h63)) |=> $stable(routeFlat));

  // R7
  quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slotPins) == '0) |-> (legacyIrq == '0));

  // R5
  four_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(legacyIrq) <= 4));

endmodule

bind pci_irq_router irq_router_chk #(
  .NUM_SLOTS  (NUM_SLOTS),
  .NUM_LEGACY (NUM_LEGACY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slotPins  (slotPins),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .legacyIrq (legacyIrq),
  .routeFlat (routeFlat)
);

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;

  localparam int NS = 8;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS*4-1:0] slotPins = '0;
  logic          regWe = 1'b0;
  logic [7:0]    regAddr = 8'h00;
  logic [7:0]    regWdata = 8'h00;
  logic [7:0]    regRdata, rd1;
  logic [NL-1:0] legacyIrq, irq1;
  logic [7:0]    addr1 = 8'h00;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS), .NUM_LEGACY(NL), .RESET_PROFILE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .slotPins(slotPins), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .legacyIrq(legacyIrq));

  pci_irq_router #(.NUM_SLOTS(NS), .NUM_LEGACY(NL), .RESET_PROFILE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .slotPins(slotPins), .regWe(1'b0),
    .regAddr(addr1), .regWdata(8'h00), .regRdata(rd1), .legacyIrq(irq1));

  // {routes line D..A, pins, expected}
  localparam logic [79:0] VEC [6] = '{
    {32'h03020100, 32'h00000001, 16'h0001},
    {32'h03020100, 32'h00000010, 16'h0002},
    {32'h05050505, 32'h00000800, 16'h0020},
    {32'h800C800C, 32'h00000002, 16'h0000},
    {32'h800C800C, 32'h00000004, 16'h1000},
    {32'h0F100900, 32'hFFFFFFFF, 16'h8201}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0;
  endtask

  task automatic setRoutes(input logic [31:0] r);
    for (int k = 0; k < 4; k++) wr(8'h60 + 8'(k), r[k*8 +: 8]);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0] lineRoute [4];
    repeat (3) @(negedge clk);
    chk("R6 reset output", 32'(legacyIrq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset contents, both profiles
    for (int k = 0; k < 4; k++) begin
      rd(8'h60 + 8'(k), d);
      chk("R6 profile0 route", 32'(d), 32'h80);
      addr1 = 8'h60 + 8'(k); #1;
      chk("R6 profile1 route", 32'(rd1), (k < 2) ? 32'h0A : 32'h0B);
    end
    slotPins = 32'h1;          // slot1 INTA -> line A -> input 10 on u1
    step();
    chk("R6 profile1 line A on 10", 32'(irq1), 32'h0400);
    chk("R4 disabled reset routes", 32'(legacyIrq), 32'h0);
    slotPins = 32'h00000040;   // slot2 INTC -> line D -> input 11 on u1
    step();
    chk("R1 R6 profile1 line D on 11", 32'(irq1), 32'h0800);
    slotPins = '0;
    step();

    // table of vectors
    for (int i = 0; i < 6; i++) begin
      setRoutes(VEC[i][79:48]);
      slotPins = VEC[i][47:16];
      step();
      chk("R5 vector", 32'(legacyIrq), 32'(VEC[i][15:0]));
      slotPins = '0;
      step();
    end

    // R1 sweep of every slot and pin with distinct routes per line
    lineRoute[0] = 4'd2; lineRoute[1] = 4'd5; lineRoute[2] = 4'd9; lineRoute[3] = 4'd14;
    setRoutes({4'h0, lineRoute[3], 4'h0, lineRoute[2], 4'h0, lineRoute[1], 4'h0, lineRoute[0]});
    for (int s = 1; s <= NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        slotPins = '0;
        slotPins[(s-1)*4 + p] = 1'b1;
        step();
        chk("R1 rotation", 32'(legacyIrq), 32'(1) << lineRoute[(p + s - 1) % 4]);
      end
    end
    slotPins = '0;
    step();

    // R4 sweep of steering values on line A, others disabled
    setRoutes(32'h80808000);
    slotPins = 32'h1;
    for (int v = 0; v < 32; v++) begin
      wr(8'h60, 8'(v));
      chk("R4 R7 steering value", 32'(legacyIrq), (v < 16) ? (32'(1) << v) : 32'h0);
    end
    wr(8'h60, 8'hFF);
    chk("R4 value FF routes nowhere", 32'(legacyIrq), 32'h0);

    // R5 shared target: every line on input 7
    setRoutes(32'h07070707);
    for (int k = 0; k < 4; k++) begin
      slotPins = '0;
      slotPins[k] = 1'b1;
      step();
      chk("R5 shared input 7", 32'(legacyIrq), 32'h0080);
    end
    slotPins = 32'h0000000F;
    step();
    chk("R5 shared all lines", 32'(legacyIrq), 32'h0080);

    // R7 latency: pin change not visible before the edge
    slotPins = '0;
    #1;
    chk("R7 before edge", 32'(legacyIrq), 32'h0080);
    step();
    chk("R7 after edge", 32'(legacyIrq), 32'h0);

    // R2 read-back and foreign addresses
    setRoutes(32'h3C2B1A09);
    for (int k = 0; k < 4; k++) begin
      rd(8'h60 + 8'(k), d);
      chk("R2 readback", 32'(d), 32'(8'h09 + 8'(k) * 8'h11));
    end
    rd(8'h5F, d); chk("R2 foreign read 5F", 32'(d), 32'h0);
    rd(8'h64, d); chk("R2 foreign read 64", 32'(d), 32'h0);

    // R3 foreign writes ignored
    slotPins = 32'h1;        // line A -> input 9
    step();
    wr(8'h5F, 8'h03);
    wr(8'h64, 8'h03);
    wr(8'h00, 8'h03);
    chk("R3 output after foreign writes", 32'(legacyIrq), 32'h0200);
    for (int k = 0; k < 4; k++) begin
      rd(8'h60 + 8'(k), d);
      chk("R3 routes after foreign writes", 32'(d), 32'(8'h09 + 8'(k) * 8'h11));
    end

    // R6 mid-run reset clears levels and reloads routes
    rst_n = 1'b0;
    #1;
    chk("R6 mid reset output", 32'(legacyIrq), 32'h0);
    rd(8'h60, d);
    chk("R6 mid reset route", 32'(d), 32'h80);
    @(negedge clk);
    rst_n = 1'b1;
    wr(8'h60, 8'h04);
    chk("R6 R7 after reset", 32'(legacyIrq), 32'h0010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule